// File: doc/BRIEF.md
# Converter control and result registers

This block is the register back end of a sampling converter peripheral. A serial target front end hands it whole bytes. A written byte updates an 8-bit configuration register. A read transaction streams out the 16-bit conversion result and then the configuration byte. The block also sequences a conversion controller. That controller is modelled as a cycle counter whose length comes from a four-entry parameter table. When the count finishes, the controller loads the 16-bit sample presented on its input into the result register.

Two conversion modes exist. In single-shot mode, one conversion runs each time a start is written. In continuous mode, a new conversion begins as soon as the previous one ends. The rate and gain fields are only stored and driven out as control signals. A synchronous full-reset request, such as a decoded general-call reset, aborts any conversion and returns every register to its reset value.

Top module: `conv_regs`

## Requirements
- R1: The configuration byte reads as {busy, 0, 0, single, rate[1:0], gain[1:0]}. Bit 7 is busy, bits 6:5 always read 0, bit 4 is single (1 = single-shot, 0 = continuous), bits 3:2 are rate and bits 1:0 are gain. A write stores bits 4:0, and `rate_o`/`gain_o`/`single_o` follow the stored fields from the next cycle.
- R2: After reset the configuration byte reads 0x8C: continuous mode, rate 3, gain 0, and bit 7 = 1 because the converter is running. The first read byte is 0x00.
- R3: In single-shot mode, writing a byte with bits 7 and 4 set while idle starts exactly one conversion. `busy_o` is 1 from the next cycle until completion and 0 afterwards. Writing bit 7 = 0 starts nothing.
- R4: In continuous mode the written bit 7 is ignored. A conversion starts on its own when the converter is idle, and a new one starts on the completing cycle, so `busy_o` stays 1.
- R5: A conversion lasts `CYC_Rn` cycles, where n is the rate field. `done_o` is high for one cycle, one cycle after the completing edge.
- R6: On completion `sample_i` loads into the result register. The result reads 0x0000 until the first conversion after reset completes.
- R7: `full_rst_i` aborts a conversion in progress and clears the result and the read snapshot. It restores the 0x8C configuration, which restarts the converter in continuous mode, and returns the read pointer to the first byte.
- R8: After `rd_start_i`, the bytes returned are result[15:8], then result[7:0], then the configuration byte. Each `rd_next_i` advances one byte, and the configuration byte repeats for any further bytes.
- R9: The result is captured when `rd_start_i` is seen. The two result bytes of that transaction do not change if a conversion completes during the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| full_rst_i | input | 1 | Synchronous full-reset request |
| wr_valid_i | input | 1 | Write byte strobe |
| wr_data_i | input | 8 | Configuration byte written |
| rd_start_i | input | 1 | Start of a read transaction |
| rd_next_i | input | 1 | Advance to the next read byte |
| rd_data_o | output | 8 | Current read byte |
| sample_i | input | 16 | Sample loaded at conversion end |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Conversion completed pulse |
| single_o | output | 1 | Single-shot mode selected |
| rate_o | output | 2 | Stored rate field |
| gain_o | output | 2 | Stored gain field |

## Verification
The assertions assume that every entry of the length table is at least 2, so two `done_o` pulses can never be adjacent. They also assume `full_rst_i` is a synchronous single-cycle-or-longer request that outranks `rd_start_i` and writes. The bench keeps to these limits: it uses lengths 4, 6, 8 and 12, and changes all inputs only on falling edges. It drives stimulus into mode switches while a conversion is in flight, writes during busy, completions inside an open read, and a full reset in mid-count.

// File: rtl/conv_regs_pkg.sv
package conv_regs_pkg;
  localparam int RES_W = 16;
  localparam int BIT_START = 7;
  localparam int BIT_SINGLE = 4;
  localparam logic [7:0] CFG_RST_BYTE = 8'h8C;

  typedef struct packed {
    logic       single;
    logic [1:0] rate;
    logic [1:0] gain;
  } cfg_t;

  typedef enum logic [1:0] {RD_HI = 2'd0, RD_LO = 2'd1, RD_CFG = 2'd2} rd_sel_e;

  function automatic cfg_t byte_to_cfg(logic [7:0] b);
    cfg_t c;
    c.single = b[BIT_SINGLE];
    c.rate   = b[3:2];
    c.gain   = b[1:0];
    return c;
  endfunction

  function automatic logic [7:0] cfg_to_byte(cfg_t c, logic busy);
    return {busy, 2'b00, c.single, c.rate, c.gain};
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  localparam cfg_t CFG_RST = byte_to_cfg(CFG_RST_BYTE);
endpackage

// File: rtl/conv_cfg_reg.sv
module conv_cfg_reg
  import conv_regs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       wr_valid_i,
  input  logic [7:0] wr_data_i,
  output cfg_t       cfg_o,
  output logic       start_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cfg_q <= CFG_RST;
    else if (clr_i)      cfg_q <= CFG_RST;
    else if (wr_valid_i) cfg_q <= byte_to_cfg(wr_data_i);
  end

  // start request only counts when the same byte selects single-shot
  assign start_o = wr_valid_i && !clr_i && wr_data_i[BIT_SINGLE] && wr_data_i[BIT_START];
  assign cfg_o   = cfg_q;
endmodule

// File: rtl/conv_engine.sv
module conv_engine
  import conv_regs_pkg::*;
#(
  parameter int unsigned CYC_R0 = 4,
  parameter int unsigned CYC_R1 = 6,
  parameter int unsigned CYC_R2 = 8,
  parameter int unsigned CYC_R3 = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             single_i,
  input  logic [1:0]       rate_i,
  input  logic             start_i,
  input  logic [RES_W-1:0] sample_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);
  localparam int unsigned CYC_MAX = max2(max2(CYC_R0, CYC_R1), max2(CYC_R2, CYC_R3));
  localparam int CNT_W = (CYC_MAX > 2) ? $clog2(CYC_MAX) : 1;
  localparam int unsigned CYC_TAB [4] = '{CYC_R0, CYC_R1, CYC_R2, CYC_R3};
  localparam logic RUN_RST = !CFG_RST.single;

  logic [CNT_W-1:0] len_tab [4];
  logic [CNT_W-1:0] cnt_q;
  logic             running_q, done_q, last;
  logic [RES_W-1:0] result_q;

  for (genvar i = 0; i < 4; i++) begin : g_len
    assign len_tab[i] = CNT_W'(CYC_TAB[i] - 1);
  end

  // >= so a rate change mid-count cannot overrun the counter
  assign last = running_q && (cnt_q >= len_tab[rate_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= RUN_RST;
      cnt_q     <= '0;
      result_q  <= '0;
      done_q    <= 1'b0;
    end else if (clr_i) begin
      running_q <= RUN_RST;
      cnt_q     <= '0;
      result_q  <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= last;
      if (last) begin
        result_q  <= sample_i;
        cnt_q     <= '0;
        running_q <= !single_i;
      end else if (running_q) begin
        cnt_q <= cnt_q + 1'b1;
      end else if (!single_i || start_i) begin
        running_q <= 1'b1;
        cnt_q     <= '0;
      end
    end
  end

  assign busy_o   = running_q;
  assign done_o   = done_q;
  assign result_o = result_q;
endmodule

// File: rtl/conv_rd_port.sv
module conv_rd_port
  import conv_regs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             rd_start_i,
  input  logic             rd_next_i,
  input  logic [RES_W-1:0] result_i,
  input  logic [7:0]       cfg_byte_i,
  output logic [7:0]       rd_data_o,
  output rd_sel_e          ptr_o,
  output logic [RES_W-1:0] snap_o
);
  rd_sel_e          ptr_q;
  logic [RES_W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= RD_HI;
      snap_q <= '0;
    end else if (clr_i) begin
      ptr_q  <= RD_HI;
      snap_q <= '0;
    end else if (rd_start_i) begin
      ptr_q  <= RD_HI;
      snap_q <= result_i;
    end else if (rd_next_i) begin
      unique case (ptr_q)
        RD_HI:   ptr_q <= RD_LO;
        RD_LO:   ptr_q <= RD_CFG;
        default: ptr_q <= RD_CFG;
      endcase
    end
  end

  always_comb begin
    unique case (ptr_q)
      RD_HI:   rd_data_o = snap_q[15:8];
      RD_LO:   rd_data_o = snap_q[7:0];
      default: rd_data_o = cfg_byte_i;
    endcase
  end

  assign ptr_o  = ptr_q;
  assign snap_o = snap_q;
endmodule

// File: rtl/conv_regs.sv
module conv_regs
  import conv_regs_pkg::*;
#(
  parameter int unsigned CYC_R0 = 4,
  parameter int unsigned CYC_R1 = 6,
  parameter int unsigned CYC_R2 = 8,
  parameter int unsigned CYC_R3 = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        full_rst_i,
  input  logic        wr_valid_i,
  input  logic [7:0]  wr_data_i,
  input  logic        rd_start_i,
  input  logic        rd_next_i,
  output logic [7:0]  rd_data_o,
  input  logic [15:0] sample_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        single_o,
  output logic [1:0]  rate_o,
  output logic [1:0]  gain_o
);
  cfg_t             cfg_w;
  logic             start_w;
  logic [RES_W-1:0] result_w;
  logic [RES_W-1:0] snap_w;
  rd_sel_e          ptr_w;

  conv_cfg_reg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (full_rst_i),
    .wr_valid_i (wr_valid_i),
    .wr_data_i  (wr_data_i),
    .cfg_o      (cfg_w),
    .start_o    (start_w)
  );

  conv_engine #(
    .CYC_R0 (CYC_R0),
    .CYC_R1 (CYC_R1),
    .CYC_R2 (CYC_R2),
    .CYC_R3 (CYC_R3)
  ) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (full_rst_i),
    .single_i (cfg_w.single),
    .rate_i   (cfg_w.rate),
    .start_i  (start_w),
    .sample_i (sample_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_w)
  );

  conv_rd_port u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (full_rst_i),
    .rd_start_i (rd_start_i),
    .rd_next_i  (rd_next_i),
    .result_i   (result_w),
    .cfg_byte_i (cfg_to_byte(cfg_w, busy_o)),
    .rd_data_o  (rd_data_o),
    .ptr_o      (ptr_w),
    .snap_o     (snap_w)
  );

  assign single_o = cfg_w.single;
  assign rate_o   = cfg_w.rate;
  assign gain_o   = cfg_w.gain;
endmodule

// File: rtl/conv_regs_chk.sv
module conv_regs_chk
  import conv_regs_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             full_rst_i,
  input logic             rd_start_i,
  input logic             rd_next_i,
  input logic [7:0]       rd_data_i,
  input logic [RES_W-1:0] sample_i,
  input logic             busy_i,
  input logic             done_i,
  input logic             single_i,
  input logic [1:0]       rate_i,
  input logic [1:0]       gain_i,
  input rd_sel_e          ptr_i,
  input logic [RES_W-1:0] snap_i,
  input logic [RES_W-1:0] result_i
);
  assert_rsvd_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_i == RD_CFG) |-> (rd_data_i[6:5] == 2'b00));

  assert_fields_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_i == RD_CFG) |-> (rd_data_i[4:0] == {single_i, rate_i, gain_i} && rd_data_i[7] == busy_i));

  assert_single_stop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && $past(single_i)) |-> !busy_i);

  assert_cont_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !$past(single_i)) |-> busy_i);

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  assert_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (result_i == $past(sample_i)));

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(full_rst_i) |-> (result_i == '0 && !done_i && ptr_i == RD_HI && snap_i == '0));

  assert_ptr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_next_i && !rd_start_i && !full_rst_i && ptr_i == RD_CFG) |=> (ptr_i == RD_CFG));

  assert_snap_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_start_i && !full_rst_i) |=> $stable(snap_i));
endmodule

bind conv_regs conv_regs_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .full_rst_i (full_rst_i),
  .rd_start_i (rd_start_i),
  .rd_next_i  (rd_next_i),
  .rd_data_i  (rd_data_o),
  .sample_i   (sample_i),
  .busy_i     (busy_o),
  .done_i     (done_o),
  .single_i   (single_o),
  .rate_i     (rate_o),
  .gain_i     (gain_o),
  .ptr_i      (ptr_w),
  .snap_i     (snap_w),
  .result_i   (result_w)
);

// File: tb/conv_regs_tb.sv
module conv_regs_tb;
  localparam int C0 = 4, C1 = 6, C2 = 8, C3 = 12;

  logic        clk = 0, rst_n = 0, full_rst = 0, wr_valid = 0, rd_start = 0, rd_next = 0;
  logic [7:0]  wr_data = 0;
  logic [15:0] sample = 16'h1234;
  logic [7:0]  rd_data;
  logic        busy, done, single;
  logic [1:0]  rate, gain;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  conv_regs #(.CYC_R0(C0), .CYC_R1(C1), .CYC_R2(C2), .CYC_R3(C3)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .full_rst_i(full_rst), .wr_valid_i(wr_valid),
    .wr_data_i(wr_data), .rd_start_i(rd_start), .rd_next_i(rd_next), .rd_data_o(rd_data),
    .sample_i(sample), .busy_o(busy), .done_o(done), .single_o(single),
    .rate_o(rate), .gain_o(gain)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  int m_run, m_cnt, m_sc, m_dr, m_pga, m_res, m_snap, m_ptr, m_done;

  function automatic int len_of(int d);
    case (d)
      0: return C0;
      1: return C1;
      2: return C2;
      default: return C3;
    endcase
  endfunction

  function automatic int m_cfg_byte();
    return (m_run << 7) | (m_sc << 4) | (m_dr << 2) | m_pga;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || full_rst) begin
      m_run = 1; m_cnt = 0; m_sc = 0; m_dr = 3; m_pga = 0;
      m_res = 0; m_snap = 0; m_ptr = 0; m_done = 0;
    end else begin
      int n_run, n_cnt, n_res, n_done, n_snap, n_ptr;
      n_run = m_run; n_cnt = m_cnt; n_res = m_res; n_done = 0;
      n_snap = m_snap; n_ptr = m_ptr;
      if (m_run != 0) begin
        if (m_cnt >= len_of(m_dr) - 1) begin
          n_res = int'(sample); n_done = 1; n_cnt = 0;
          n_run = (m_sc != 0) ? 0 : 1;
        end else n_cnt = m_cnt + 1;
      end else if (m_sc == 0) begin
        n_run = 1; n_cnt = 0;
      end
      if (wr_valid) begin
        if (m_run == 0 && wr_data[4] && wr_data[7]) begin
          n_run = 1; n_cnt = 0;
        end
        m_sc = int'(wr_data[4]); m_dr = int'(wr_data[3:2]); m_pga = int'(wr_data[1:0]);
      end
      if (rd_start) begin
        n_ptr = 0; n_snap = m_res;
      end else if (rd_next && m_ptr < 2) n_ptr = m_ptr + 1;
      m_run = n_run; m_cnt = n_cnt; m_res = n_res; m_done = n_done;
      m_snap = n_snap; m_ptr = n_ptr;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      int exp_rd;
      exp_rd = (m_ptr == 0) ? (m_snap >> 8) : (m_ptr == 1) ? (m_snap & 255) : m_cfg_byte();
      chk((m_ptr < 2) ? "R8 model rd byte" : "R1 model cfg byte", 32'(rd_data), 32'(exp_rd));
      chk("R3 model busy", 32'(busy), 32'(m_run));
      chk("R5 model done", 32'(done), 32'(m_done));
      chk("R1 model fields", 32'({single, rate, gain}), 32'((m_sc << 4) | (m_dr << 2) | m_pga));
    end
  end

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_valid = 1; wr_data = b;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic rd4(output logic [7:0] b0, output logic [7:0] b1,
                     output logic [7:0] b2, output logic [7:0] b3);
    @(negedge clk); rd_start = 1;
    @(negedge clk); rd_start = 0; b0 = rd_data; rd_next = 1;
    @(negedge clk); b1 = rd_data;
    @(negedge clk); b2 = rd_data;
    @(negedge clk); b3 = rd_data; rd_next = 0;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    do begin
      @(posedge clk); #1; k++;
    end while (!done && k < 1000);
  endtask

  task automatic measure(input logic [7:0] b, input int exp_len);
    int k;
    @(negedge clk); wr_valid = 1; wr_data = b;
    @(posedge clk);
    @(negedge clk); wr_valid = 0;
    chk("R3 busy during single-shot", 32'(busy), 32'd1);
    k = 1;
    while (!done && k < 1000) begin
      @(posedge clk); #1;
      if (!done) k++;
    end
    chk("R5 conversion length", 32'(k), 32'(exp_len));
    chk("R3 idle after single-shot", 32'(busy), 32'd0);
  endtask

  initial begin
    logic [7:0] b0, b1, b2, b3;
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2 first byte after reset", 32'(rd_data), 32'h00);
    chk("R2 busy after reset", 32'(busy), 32'd1);
    rd4(b0, b1, b2, b3);
    chk("R6 result hi zero", 32'(b0), 32'h00);
    chk("R6 result lo zero", 32'(b1), 32'h00);
    chk("R2 cfg reset byte", 32'(b2), 32'h8C);
    chk("R8 cfg repeats", 32'(b3), 32'h8C);

    wait_done(k);
    rd4(b0, b1, b2, b3);
    chk("R6 result hi", 32'(b0), 32'h12);
    chk("R6 result lo", 32'(b1), 32'h34);
    chk("R8 third byte cfg", 32'(b2), 32'h8C);

    // switch to single-shot with bit7 = 0: running conversion finishes, none follows
    wr(8'h11);
    repeat (20) @(negedge clk);
    chk("R3 stops in single-shot", 32'(busy), 32'd0);
    wr(8'h11);
    chk("R3 write 0 no start", 32'(busy), 32'd0);
    sample = 16'h8001;
    measure(8'h91, C0);
    rd4(b0, b1, b2, b3);
    chk("R6 single result hi", 32'(b0), 32'h80);
    chk("R6 single result lo", 32'(b1), 32'h01);
    chk("R1 cfg single idle", 32'(b2), 32'h11);
    measure(8'h9D, C3);

    // continuous: bit7 ignored, auto restart
    wr(8'h0E);
    @(negedge clk);
    chk("R4 auto start", 32'(busy), 32'd1);
    wr(8'h0E);
    chk("R4 bit7=0 ignored", 32'(busy), 32'd1);
    wr(8'h8E);
    rd4(b0, b1, b2, b3);
    chk("R4 cfg running", 32'(b2), 32'h8E);
    wait_done(k);
    @(negedge clk);
    chk("R4 restart after done", 32'(busy), 32'd1);

    // snapshot across a completion
    @(negedge clk); rd_start = 1;
    @(negedge clk); rd_start = 0; sample = 16'hABCD;
    wait_done(k);
    @(negedge clk); b0 = rd_data; rd_next = 1;
    @(negedge clk); b1 = rd_data; rd_next = 0;
    chk("R9 snapshot hi", 32'(b0), 32'h80);
    chk("R9 snapshot lo", 32'(b1), 32'h01);
    rd4(b0, b1, b2, b3);
    chk("R6 new result hi", 32'(b0), 32'hAB);
    chk("R6 new result lo", 32'(b1), 32'hCD);

    // reserved bits and field outputs
    wr(8'h6B);
    chk("R1 rate_o", 32'(rate), 32'd2);
    chk("R1 gain_o", 32'(gain), 32'd3);
    chk("R1 single_o", 32'(single), 32'd0);
    rd4(b0, b1, b2, b3);
    chk("R1 reserved read zero", 32'(b2), 32'h8B);

    // full reset mid-conversion
    wr(8'h19);
    repeat (20) @(negedge clk);
    wr(8'h99);
    @(negedge clk); rd_start = 1;
    @(negedge clk); rd_start = 0; rd_next = 1;
    @(negedge clk);
    @(negedge clk); rd_next = 0;
    chk("R8 pointer at cfg before reset", 32'(rd_data), 32'h99);
    full_rst = 1;
    @(negedge clk); full_rst = 0;
    chk("R7 pointer back to first byte", 32'(rd_data), 32'h00);
    chk("R7 no done after abort", 32'(done), 32'd0);
    chk("R7 continuous restart", 32'(busy), 32'd1);
    rd4(b0, b1, b2, b3);
    chk("R7 result cleared hi", 32'(b0), 32'h00);
    chk("R7 result cleared lo", 32'(b1), 32'h00);
    chk("R7 cfg default", 32'(b2), 32'h8C);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R5 act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule